// File: doc/BRIEF.md
# Secure DRAM Region Access Filter

This block sits in front of a DRAM port and rules on every access it is shown. For each address it says whether a non-secure master may reach that address. Software programs up to eight address windows. Each window is given in whole megabytes, with an inclusive upper bound. A control word then decides three things: which windows are protected, whether memory covered by no window is protected, and whether the whole filter is switched off so that all memory is open.

The block has two ports. The register port takes one-cycle writes and combinational reads of 17 words. In every written 32-bit word, the upper half is a per-bit write-enable for the lower half. The check port takes an address and a secure attribute, and returns allow or deny in the same cycle. The bus protocol and the error response to a denied access belong to the surrounding logic.

Top module: `secfilt_top`

## Requirements
- R1: After reset every window bound reads 0 and the control word reads 0x200. Only the open bit (bit 9) is set, so every access is allowed.
- R2: A write to word `regWrData` changes lower-half bit i of the selected register only when bit 16+i is 1. All other bits keep their value. The new value is visible from the clock edge after the write.
- R3: Register index n (0 to 7) is the lower bound of window n and index n+8 is its upper bound. Each bound keeps 12 bits (address bits 31:20), and bits above read as 0. Index 16 is the control word, which keeps bits 0 to 9. Writes to indices 17 to 31 change nothing, and those indices read as 0.
- R4: `regRdData` shows the addressed register in the same cycle, with bits 31:16 always 0.
- R5: Window n contains an address when lower ≤ address[31:20] ≤ upper. A window with lower 0 and upper 0 covers 0x0 to 0xFFFFF. A window whose lower bound exceeds its upper bound contains nothing.
- R6: Control bit n (0 to 7) protects window n. A non-secure access inside a window with its bit set is denied. A window with its bit clear grants access to what it contains.
- R7: An address inside no window is denied to non-secure accesses exactly when control bit 8 is set.
- R8: An address inside several windows is denied to non-secure accesses if any of those windows is protected.
- R9: While control bit 9 is set, every access is allowed, whatever the window settings.
- R10: An access with `chkSecure` high is always allowed.
- R11: `chkAllow` follows `chkAddr`, `chkSecure` and the current register contents combinationally, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 5 | Register index for both read and write |
| regWrData | input | 32 | Write word: bits 31:16 are the mask, bits 15:0 the data |
| regRdData | output | 32 | Contents of the addressed register |
| chkAddr | input | 32 | Byte address of the access under check |
| chkSecure | input | 1 | 1 when the access is secure |
| chkAllow | output | 1 | 1 when the access may proceed |

## Verification
The bench targets the exact megabyte edges of a window: the last byte below it, its first and last bytes, and the first byte past it. A design with an exclusive upper bound, or one that compared low address bits, would pass one of those edge bytes wrongly. It also overlaps a protected window on an open one, and places an open window inside protected rest-of-memory. A design that let the last matching window win, or that treated open windows as absent, would then grant or deny the wrong address. Partially masked writes and writes to unused indices show up on readback: a design ignoring the mask or aliasing high indices would corrupt neighbouring bits or words. A long stretch of random writes and checks is compared every cycle against a behavioural model.

// File: rtl/secfilt_pkg.sv
package secfilt_pkg;
  localparam int NUM_RGN  = 8;
  localparam int NUM_REG  = 2 * NUM_RGN + 1;
  localparam int CTRL_IDX = 2 * NUM_RGN;
  localparam int IDX_W    = 5;
  localparam int HALF_W   = 16;
  localparam int CTRL_W   = NUM_RGN + 2;
  localparam int REST_BIT = NUM_RGN;
  localparam int OPEN_BIT = NUM_RGN + 1;

  typedef struct packed {
    logic [NUM_REG-1:0] wrStb;
    logic [HALF_W-1:0]  bitMask;
    logic [HALF_W-1:0]  bitData;
  } regStrobe_t;

  function automatic logic [HALF_W-1:0] mergeBits(
    input logic [HALF_W-1:0] oldVal,
    input logic [HALF_W-1:0] newVal,
    input logic [HALF_W-1:0] mask
  );
    return (oldVal & ~mask) | (newVal & mask);
  endfunction
endpackage

// File: rtl/secfilt_regctl.sv
module secfilt_regctl
  import secfilt_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     regWrEn,
  input  logic [IDX_W-1:0]         regAddr,
  input  logic [2*HALF_W-1:0]      regWrData,
  output regStrobe_t               strb
);
  for (genvar i = 0; i < NUM_REG; i++) begin : gStb
    assign strb.wrStb[i] = regWrEn && (regAddr == IDX_W'(i));
  end
  assign strb.bitMask = regWrData[2*HALF_W-1:HALF_W];
  assign strb.bitData = regWrData[HALF_W-1:0];

  // R3: at most one register is targeted by any write
  assert_one_target_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb.wrStb));

  // R3: indices past the map never produce a strobe
  assert_high_idx_ignored_R3: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr >= IDX_W'(NUM_REG)) |-> (strb.wrStb == '0));
endmodule

// File: rtl/secfilt_datapath.sv
module secfilt_datapath
  import secfilt_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int MB_SHIFT = 20
) (
  input  logic                clk,
  input  logic                rstN,
  input  regStrobe_t          strb,
  input  logic [IDX_W-1:0]    regAddr,
  output logic [2*HALF_W-1:0] regRdData,
  input  logic [ADDR_W-1:0]   chkAddr,
  input  logic                chkSecure,
  output logic                chkAllow
);
  localparam int MB_W = ADDR_W - MB_SHIFT;

  logic [MB_W-1:0]    lowQ  [NUM_RGN];
  logic [MB_W-1:0]    highQ [NUM_RGN];
  logic [CTRL_W-1:0]  ctrlQ;
  logic [MB_W-1:0]    accMb;
  logic [NUM_RGN-1:0] inRgn;
  logic               anyIn;
  logic               protHit;
  logic [HALF_W-1:0]  rdWord;

  assign accMb = chkAddr[ADDR_W-1:MB_SHIFT];

  for (genvar n = 0; n < NUM_RGN; n++) begin : gRgn
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        lowQ[n]  <= '0;
        highQ[n] <= '0;
      end else begin
        if (strb.wrStb[n])
          lowQ[n] <= MB_W'(mergeBits(HALF_W'(lowQ[n]), strb.bitData, strb.bitMask));
        if (strb.wrStb[n+NUM_RGN])
          highQ[n] <= MB_W'(mergeBits(HALF_W'(highQ[n]), strb.bitData, strb.bitMask));
      end
    end
    assign inRgn[n] = (lowQ[n] <= accMb) && (accMb <= highQ[n]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      ctrlQ <= CTRL_W'(1) << OPEN_BIT;
    else if (strb.wrStb[CTRL_IDX])
      ctrlQ <= CTRL_W'(mergeBits(HALF_W'(ctrlQ), strb.bitData, strb.bitMask));
  end

  assign anyIn   = |inRgn;
  assign protHit = |(inRgn & ctrlQ[NUM_RGN-1:0]);

  always_comb begin
    if (chkSecure || ctrlQ[OPEN_BIT])
      chkAllow = 1'b1;
    else if (anyIn)
      chkAllow = !protHit;
    else
      chkAllow = !ctrlQ[REST_BIT];
  end

  always_comb begin
    rdWord = '0;
    for (int i = 0; i < NUM_RGN; i++) begin
      if (regAddr == IDX_W'(i))           rdWord = HALF_W'(lowQ[i]);
      if (regAddr == IDX_W'(i + NUM_RGN)) rdWord = HALF_W'(highQ[i]);
    end
    if (regAddr == IDX_W'(CTRL_IDX)) rdWord = HALF_W'(ctrlQ);
  end
  assign regRdData = {{HALF_W{1'b0}}, rdWord};

  // R10: secure masters pass unconditionally
  assert_secure_pass_R10: assert property (@(posedge clk) disable iff (!rstN)
    chkSecure |-> chkAllow);

  // R9: open bit overrides every window
  assert_open_pass_R9: assert property (@(posedge clk) disable iff (!rstN)
    ctrlQ[OPEN_BIT] |-> chkAllow);

  // R2: masked-off control bits keep their value across a write
  assert_mask_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrStb[CTRL_IDX] |=>
      (((ctrlQ ^ $past(ctrlQ)) & ~$past(strb.bitMask[CTRL_W-1:0])) == '0));

  // R3: control word changes only when addressed
  assert_ctrl_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrStb[CTRL_IDX] |=> $stable(ctrlQ));
endmodule

// File: rtl/secfilt_top.sv
module secfilt_top
  import secfilt_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [4:0]        regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic [ADDR_W-1:0] chkAddr,
  input  logic              chkSecure,
  output logic              chkAllow
);
  regStrobe_t strb;

  secfilt_regctl uCtl (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .strb      (strb)
  );

  secfilt_datapath #(.ADDR_W(ADDR_W)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .regAddr   (regAddr),
    .regRdData (regRdData),
    .chkAddr   (chkAddr),
    .chkSecure (chkSecure),
    .chkAllow  (chkAllow)
  );
endmodule

// File: tb/tb_secfilt_top.sv
module tb_secfilt_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [4:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [31:0] chkAddr = '0;
  logic        chkSecure = 1'b0;
  logic        chkAllow;

  int  nChecks = 0;
  int  nFails = 0;
  bit  finished = 1'b0;
  int  mReg [17];

  always #(CLK_PERIOD/2) clk = ~clk;

  secfilt_top dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .chkAddr(chkAddr),
    .chkSecure(chkSecure), .chkAllow(chkAllow)
  );

  // behavioural reference: register file updated on the same edge as the design
  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 16; i++) mReg[i] = 0;
      mReg[16] = 32'h200;
    end else if (regWrEn && regAddr <= 5'd16) begin
      int keep;
      int m;
      int d;
      keep = (regAddr < 5'd16) ? 32'hFFF : 32'h3FF;
      m = int'(regWrData[31:16]);
      d = int'(regWrData[15:0]);
      mReg[regAddr] = ((mReg[regAddr] & ~m) | (d & m)) & keep;
    end
  end

  function automatic int mRead(input int idx);
    return (idx <= 16) ? mReg[idx] : 0;
  endfunction

  function automatic bit mAllow(input logic [31:0] a, input bit sec);
    int mb;
    bit inAny;
    bit prot;
    if (sec) return 1'b1;
    if (mReg[16][9]) return 1'b1;
    mb = int'(a[31:20]);
    inAny = 1'b0;
    prot = 1'b0;
    for (int r = 0; r < 8; r++) begin
      if (mReg[r] <= mb && mb <= mReg[r+8]) begin
        inAny = 1'b1;
        if (mReg[16][r]) prot = 1'b1;
      end
    end
    return inAny ? !prot : !mReg[16][8];
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [15:0] mask, input logic [15:0] data);
    @(negedge clk);
    regWrEn = 1'b1;
    regAddr = 5'(idx);
    regWrData = {mask, data};
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdChk(input string tag, input int idx, input int exp);
    @(negedge clk);
    regAddr = 5'(idx);
    #1;
    check(tag, int'(regRdData), exp);
    check(tag, int'(regRdData), mRead(idx));
  endtask

  task automatic accChk(input string tag, input logic [31:0] a, input bit sec, input bit exp);
    @(negedge clk);
    chkAddr = a;
    chkSecure = sec;
    #1;
    check(tag, int'(chkAllow), int'(exp));
    check(tag, int'(chkAllow), int'(mAllow(a, sec)));
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    rdChk("R1", 0, 0);
    rdChk("R1", 15, 0);
    rdChk("R1", 16, 32'h200);
    accChk("R1", 32'h0000_0000, 1'b0, 1'b1);
    accChk("R1", 32'h7FF0_0000, 1'b0, 1'b1);

    // R2 masked writes on the control word
    wr(16, 16'h0001, 16'hFFFF);
    rdChk("R2", 16, 32'h201);
    wr(16, 16'h0200, 16'h0000);
    rdChk("R2", 16, 32'h001);
    wr(16, 16'h0000, 16'hFFFF);
    rdChk("R2", 16, 32'h001);

    // R3 map: bound widths, high indices
    wr(0, 16'hFFFF, 16'hFFFF);
    rdChk("R3", 0, 32'hFFF);
    rdChk("R3", 8, 0);
    wr(20, 16'hFFFF, 16'h1234);
    rdChk("R3", 20, 0);
    rdChk("R3", 4, 0);
    rdChk("R3", 12, 0);
    wr(16, 16'hFC00, 16'hFFFF);
    rdChk("R3", 16, 32'h001);

    // R4 same-cycle read, upper half zero
    wr(0, 16'hFFFF, 16'h0002);
    wr(8, 16'hFFFF, 16'h0003);
    @(negedge clk);
    regAddr = 5'd8;
    #1;
    check("R4", int'(regRdData), 32'h3);
    regAddr = 5'd0;
    #1;
    check("R4", int'(regRdData), 32'h2);

    // R5 inclusive megabyte edges of window 0 = MB 2..3, protected
    accChk("R5", 32'h001F_FFFF, 1'b0, 1'b1);
    accChk("R5", 32'h0020_0000, 1'b0, 1'b0);
    accChk("R5", 32'h003F_FFFF, 1'b0, 1'b0);
    accChk("R5", 32'h0040_0000, 1'b0, 1'b1);
    // R11 same-cycle response on address change
    @(negedge clk);
    chkSecure = 1'b0;
    chkAddr = 32'h0030_0000;
    #1;
    check("R11", int'(chkAllow), 0);
    chkAddr = 32'h0050_0000;
    #1;
    check("R11", int'(chkAllow), 1);

    // R10 secure access inside protected window
    accChk("R10", 32'h0020_0000, 1'b1, 1'b1);

    // R6 clearing the window bit opens it
    wr(16, 16'h0001, 16'h0000);
    accChk("R6", 32'h0020_0000, 1'b0, 1'b1);
    // window 1 = MB 0..0 protected
    wr(1, 16'hFFFF, 16'h0000);
    wr(9, 16'hFFFF, 16'h0000);
    wr(16, 16'h0002, 16'h0002);
    accChk("R5", 32'h000F_FFFF, 1'b0, 1'b0);
    accChk("R5", 32'h0010_0000, 1'b0, 1'b1);

    // R7 rest-of-memory: open window 0 carved out of protected rest
    wr(16, 16'h0100, 16'h0100);
    accChk("R7", 32'h0070_0000, 1'b0, 1'b0);
    accChk("R7", 32'h0020_0000, 1'b0, 1'b1);
    // inverted window 2 (low 6 > high 5) covers nothing
    wr(2, 16'hFFFF, 16'h0006);
    wr(10, 16'hFFFF, 16'h0005);
    wr(16, 16'h0104, 16'h0004);
    accChk("R5", 32'h0050_0000, 1'b1 ^ 1'b1, 1'b1);
    accChk("R5", 32'h0060_0000, 1'b0, 1'b1);

    // R8 overlap: protected window 3 = MB 3..3 inside open window 0
    wr(3, 16'hFFFF, 16'h0003);
    wr(11, 16'hFFFF, 16'h0003);
    wr(16, 16'h0008, 16'h0008);
    accChk("R8", 32'h0030_0000, 1'b0, 1'b0);
    accChk("R8", 32'h0020_0000, 1'b0, 1'b1);

    // R9 global open
    wr(16, 16'h0200, 16'h0200);
    accChk("R9", 32'h0030_0000, 1'b0, 1'b1);
    accChk("R9", 32'h0070_0000, 1'b0, 1'b1);
    wr(16, 16'h0200, 16'h0000);
    accChk("R9", 32'h0030_0000, 1'b0, 1'b0);

    // random stretch compared to the model every cycle
    for (int k = 0; k < 2000; k++) begin
      @(negedge clk);
      regWrEn = ($urandom_range(0, 2) == 0);
      regAddr = 5'($urandom_range(0, 18));
      regWrData = {16'($urandom), 16'($urandom_range(0, 15) |
                   (($urandom_range(0, 3) == 0) ? ($urandom << 4) : 0))};
      chkAddr = {12'($urandom_range(0, 15)), 20'($urandom)};
      chkSecure = ($urandom_range(0, 4) == 0);
      #1;
      check("R11", int'(chkAllow), int'(mAllow(chkAddr, chkSecure)));
      check("R4", int'(regRdData), mRead(int'(regAddr)));
    end
    @(negedge clk);
    regWrEn = 1'b0;
    finish();
  end
endmodule